// File: doc/BRIEF.md
# I2C Write-Only Register Target

This block is an I2C target that accepts only single-register write transactions. Each write updates one byte of an internal file of 8-bit control registers. The block samples SCL and SDA with the system clock and finds start and stop conditions in that sampled stream. It acknowledges three bytes in turn: the device address, the register address and the data. The data is held in a staging register and is copied into the file only when the stop condition arrives.

SDA is driven as an open-drain enable: when `sda_oe` is high the line is pulled low, and otherwise it is released. The device address is fixed except for its two lowest bits, which come from strap pins. A low level on the power input returns every register to its default and makes the block ignore the bus.

Top module: `i2c_wr_target`

## Requirements
- R1: A start condition (SDA falls while SCL is high) always begins a new device-address phase. A stop condition (SDA rises while SCL is high) always ends the transaction. Data bits are taken on SCL rising edges.
- R2: The first byte is acknowledged only when it equals binary 0,0,1,0,0, then strap[1], then strap[0], then a write bit of 0. Bits arrive MSB first.
- R3: If the first byte does not match, or its last bit is 1, that byte gets no acknowledge. The block then acknowledges nothing and writes nothing until the next start condition.
- R4: The second byte is acknowledged only when its upper three bits are zero. Its lower five bits select the register. A nonzero upper bit gives no acknowledge and the transaction is ignored as in R3.
- R5: The third byte is acknowledged and staged. The register changes only when the stop condition arrives. It does not change at the data acknowledge.
- R6: Bytes after the third are not acknowledged. Only the third byte is written at stop, so each transaction writes exactly one register.
- R7: A repeated start before the stop discards the staged data without writing. Decoding of a new device address then begins.
- R8: `sda_oe` is high only during acknowledge slots. It changes only while the sampled SCL is low, following a detected SCL falling edge, except when a power-down clears it.
- R9: While `pwr_on` is low, every register holds its default value and no byte is acknowledged. If a power-down and a stop fall in the same clock cycle, the power-down wins and nothing is written.
- R10: After reset every register holds its default value (0x00 by default) and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which samples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Low: registers return to defaults and the bus is ignored |
| strap | input | 2 | Low two bits of the device address |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low |
| regs_o | output | NREG*8 | Register file, register k at bits [8k+7:8k] |

## Verification
A stop-condition commit and a power-down can land on the same system clock edge. The bench provokes this in two steps. It first raises SDA with SCL high to form the stop, and counts the synchronizer stages so that it knows the edge at which the block will see the stop. It then holds `pwr_on` low for exactly that one cycle. The check passes only if every register then holds its default, which shows that the power-down took priority over the staged write.

// File: rtl/i2c_wr_target.sv
module i2c_wr_target #(
  parameter logic [4:0] DEV_FIXED = 5'b00100,
  parameter int         NREG      = 32,
  parameter logic [7:0] DFLT      = 8'h00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_on,
  input  logic [1:0]      strap,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int AW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_DAT, S_XTRA, S_SKIP} st_t;

  logic [2:0] scl_p, sda_p;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, pend;
  logic [AW-1:0] ra;
  logic       pend_v, byte_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

  always_comb
    case (st)
      S_DEV:   byte_ok = (sh == {DEV_FIXED, strap, 1'b0});
      S_REG:   byte_ok = ((sh >> AW) == 8'd0);
      S_DAT:   byte_ok = 1'b1;
      default: byte_ok = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; pend <= '0; ra <= '0;
      pend_v <= 1'b0; sda_oe <= 1'b0;
    end else if (!pwr_on) begin
      st <= S_IDLE; cnt <= '0; pend_v <= 1'b0; sda_oe <= 1'b0;
    end else if (start_det) begin
      st <= S_DEV; cnt <= '0; pend_v <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; cnt <= '0; pend_v <= 1'b0;
    end else if (scl_rise && st != S_IDLE) begin
      if (cnt != 4'd8) begin
        sh  <= {sh[6:0], sda_p[1]};
        cnt <= cnt + 4'd1;
      end else begin
        cnt <= '0;
        case (st)
          S_DEV: st <= byte_ok ? S_REG : S_SKIP;
          S_REG: begin
            if (byte_ok) ra <= sh[AW-1:0];
            st <= byte_ok ? S_DAT : S_SKIP;
          end
          S_DAT: begin
            pend <= sh; pend_v <= 1'b1; st <= S_XTRA;
          end
          default: ;
        endcase
      end
    end else if (scl_fall) begin
      sda_oe <= (cnt == 4'd8) && byte_ok;
    end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                                  q <= DFLT;
        else if (!pwr_on)                            q <= DFLT;
        else if (stop_det && pend_v && ra == AW'(g)) q <= pend;
      assign regs_o[g*8 +: 8] = q;
    end
  endgenerate

  a_r1_start_dev: assert property (@(posedge clk) disable iff (!rst_n)
    start_det && pwr_on |=> st == S_DEV && cnt == 4'd0);
  a_r3_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SKIP |-> !sda_oe);
  a_r5_commit_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(stop_det) || !$past(pwr_on));
  a_r8_ack_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> cnt == 4'd8 && !scl_p[1]);
  a_r8_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_p[1]) || !$past(pwr_on));
  a_r9_power_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> regs_o == {NREG{DFLT}} && !sda_oe);
endmodule

// File: tb/i2c_wr_target_bench.sv
module i2c_wr_target_bench;
  localparam int Q = 6;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, pwr_on = 1'b1;
  logic [1:0] strap = 2'b10;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [255:0] regs;
  wire sda_ln = sda_m & ~sda_oe;

  i2c_wr_target u_i2c_wr_target (.clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .strap(strap),
    .scl_i(scl_m), .sda_i(sda_ln), .sda_oe(sda_oe), .regs_o(regs));

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mdl [32];

  // {dev, reg, data, expected acks (first byte in bit 3), write flag}
  localparam logic [27:0] VEC [8] = '{
    28'h2403A5F, 28'h241F3CF, 28'h2400FFF, 28'h2603110,
    28'h2503220, 28'h2423448, 28'h240300F, 28'h241F5AF };

  function automatic logic [255:0] mpack();
    logic [255:0] p;
    for (int i = 0; i < 32; i++) p[i*8 +: 8] = mdl[i];
    return p;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; step(Q); scl_m = 1; step(Q);
    sda_m = 0; step(Q); scl_m = 0; step(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; step(Q); scl_m = 1; step(Q); sda_m = 1; step(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; step(Q); scl_m = 1; step(2*Q); scl_m = 0; step(Q);
    end
    sda_m = 1; step(Q); scl_m = 1; step(Q);
    a = ~sda_ln;
    step(Q); scl_m = 0; step(Q);
  endtask

  task automatic xact(input logic [7:0] b0, b1, b2, output logic [2:0] ak);
    bus_start();
    send_byte(b0, ak[2]); send_byte(b1, ak[1]); send_byte(b2, ak[0]);
  endtask

  task automatic done();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      done();
    end
  end

  initial begin
    logic [2:0] ak;
    logic a;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    step(5); rst_n = 1; step(3);
    chk("R10 reset regs", regs, mpack());
    chk("R10 reset sda_oe", {255'd0, sda_oe}, 256'd0);

    for (int v = 0; v < 8; v++) begin
      xact(VEC[v][27:20], VEC[v][19:12], VEC[v][11:4], ak);
      bus_stop();
      if (VEC[v][0]) mdl[VEC[v][16:12]] = VEC[v][11:4];
      chk("R2/R3/R4 acks", {253'd0, ak}, {253'd0, VEC[v][3:1]});
      chk("R5 regs after stop", regs, mpack());
    end

    xact(8'h24, 8'h0A, 8'hC3, ak);
    chk("R5 no write before stop", regs, mpack());
    bus_stop(); mdl[10] = 8'hC3;
    chk("R5 write at stop", regs, mpack());

    xact(8'h24, 8'h05, 8'h77, ak);
    send_byte(8'h99, a);
    chk("R6 extra byte nack", {255'd0, a}, 256'd0);
    bus_stop(); mdl[5] = 8'h77;
    chk("R6 first data only", regs, mpack());

    xact(8'h24, 8'h06, 8'h88, ak);
    xact(8'h24, 8'h07, 8'h99, ak);
    bus_stop(); mdl[7] = 8'h99;
    chk("R7 repeated start acks", {253'd0, ak}, 256'd7);
    chk("R7 abandoned write", regs, mpack());

    bus_start(); send_byte(8'h26, a); send_byte(8'h08, a);
    chk("R3 ignored after nack", {255'd0, a}, 256'd0);
    xact(8'h24, 8'h08, 8'h12, ak);
    bus_stop(); mdl[8] = 8'h12;
    chk("R3 recover at start", regs, mpack());

    strap = 2'b01;
    xact(8'h22, 8'h09, 8'h4D, ak);
    bus_stop(); mdl[9] = 8'h4D;
    chk("R2 strap acks", {253'd0, ak}, 256'd7);
    chk("R2 strap write", regs, mpack());
    strap = 2'b10;

    pwr_on = 0; step(2);
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    chk("R9 defaults restored", regs, mpack());
    xact(8'h24, 8'h03, 8'h5E, ak);
    bus_stop();
    chk("R9 no ack when down", {253'd0, ak}, 256'd0);
    chk("R9 no write when down", regs, mpack());
    pwr_on = 1; step(2);

    xact(8'h24, 8'h04, 8'h6B, ak);
    sda_m = 0; step(Q); scl_m = 1; step(Q);
    sda_m = 1; step(2);
    pwr_on = 0; step(1); pwr_on = 1; step(2*Q);
    chk("R9 power beats stop", regs, mpack());

    xact(8'h24, 8'h04, 8'h6B, ak);
    bus_stop(); mdl[4] = 8'h6B;
    chk("R1 write after pulse", regs, mpack());
    done();
  end
endmodule